// File: doc/BRIEF.md
# Nested-Loop Strided Lane Address Generator

This block produces the memory addresses that one data-mover port visits while it streams a tensor tile. It walks a stack of nested counting loops over time. At every step of that walk it fans the current position out into a row of parallel lane addresses. Each lane address is the 64-bit base, plus every loop index multiplied by that loop's stride, plus the lane number multiplied by a spatial stride. The number of loops and the number of lanes are fixed when the block is built. The loop bounds, the loop strides, the spatial stride and the base are taken in at run time.

A controller presents the configuration on plain input pins and pulses `start_i` for one cycle. From the next cycle the block offers one beat of lane addresses at a time on a valid/ready output. A beat is consumed only in a cycle where `valid_o` and `ready_i` are both high. When `ready_i` is low, `valid_o` stays high and the offered addresses do not change. The downstream side may hold `ready_i` low for as long as it needs. Once the last beat has been consumed, `done_o` rises and stays high until the next start.

Top module: `stride_lane_agu`

## Requirements
- R1: After reset, `valid_o` and `done_o` are both low, and they stay low until a start pulse.
- R2: In every offered beat, lane `j` carries base + sum over loops k of (index_k × stride_k) + j × spatial stride. The arithmetic is unsigned and wraps modulo 2^64. Strides are zero-extended to 64 bits.
- R3: All lane addresses of one step are offered together in the same beat. Lane `j` occupies bits `[64*j +: 64]` of `addr_o`.
- R4: Loop 0 is the innermost loop. Its bound occupies bits `[15:0]` of `bounds_i` and its stride occupies bits `[31:0]` of `tstrides_i`; loop k sits at the k-th slot. Loop 0's index advances on each consumed beat. When an index would reach its bound, it wraps to 0 and carries one step into the next outer loop.
- R5: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `addr_o` holds its value.
- R6: In the cycle after the final beat is consumed, `valid_o` is low and `done_o` is high. Both hold that way until the next start.
- R7: A start pulse, even one in the middle of a run, loads a fresh configuration and clears every index. In the next cycle the first beat (all indices zero) is offered.
- R8: If any loop bound is zero at start, no beat is offered, and `done_o` is high in the next cycle.
- R9: The 64-bit base is formed from `base_hi_i` as the upper half and `base_lo_i` as the lower half.
- R10: Changes on the configuration inputs while no start pulse is present have no effect on the addresses being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: load configuration and begin the walk |
| base_lo_i | input | 32 | Lower half of the base pointer |
| base_hi_i | input | 32 | Upper half of the base pointer |
| bounds_i | input | NUM_LOOPS*BOUND_W | Loop bounds, loop 0 (innermost) in the lowest slot |
| tstrides_i | input | NUM_LOOPS*STRIDE_W | Loop strides, loop 0 in the lowest slot |
| sstride_i | input | STRIDE_W | Address distance between neighbouring lanes |
| addr_o | output | NUM_LANES*ADDR_W | Lane addresses of the current beat, lane 0 in the lowest slot |
| valid_o | output | 1 | A beat is offered |
| ready_i | input | 1 | Downstream accepts the offered beat |
| done_o | output | 1 | The walk is finished |

## Verification
The embedded properties watch several rules on every cycle. They check that a stalled beat keeps its addresses and its valid, that done and valid are never high together, and that done persists until a start. They also check that a zero bound at start leads straight to done, that a start offers the base on lane 0 next cycle, that lanes are spaced by the spatial stride, and that each loop index wraps to zero and stays below its bound. Only the bench scenarios can show the order in which whole sequences of addresses come out: nested carries across loops, the exact values for several base and stride choices, 64-bit wraparound, and the beat count that ends in done. The same holds for a restart in the middle of a run and for configuration changes that must be ignored.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/sag_loop_level.sv
// One temporal loop level: index counter plus running index*stride offset.
module sag_loop_level #(
  parameter int BOUND_W  = 16,
  parameter int STRIDE_W = 32,
  parameter int ADDR_W   = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                step_i,
  input  logic [BOUND_W-1:0]  bound_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic                at_last_o,
  output logic [ADDR_W-1:0]   offset_o
);
  logic [BOUND_W-1:0] idx_q;
  logic [ADDR_W-1:0]  off_q;
  logic [BOUND_W-1:0] last_idx;

  assign last_idx  = bound_i - BOUND_W'(1);
  assign at_last_o = (idx_q == last_idx);
  assign offset_o  = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (step_i) begin
      if (at_last_o) begin
        idx_q <= '0;
        off_q <= '0;
      end else begin
        idx_q <= idx_q + BOUND_W'(1);
        off_q <= off_q + ADDR_W'(stride_i);
      end
    end
  end

  // R4: a step at the last index wraps the level back to zero
  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && at_last_o |=> (idx_q == '0) && (off_q == '0));

  // R4: the index never reaches a nonzero bound
  a_r4_idx_below_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i != '0) |-> (idx_q < bound_i));
endmodule

// File: rtl/sag_lane_fanout.sv
// Expands one temporal origin into NUM_LANES spatially strided addresses.
module sag_lane_fanout #(
  parameter int NUM_LANES = 4,
  parameter int STRIDE_W  = 32,
  parameter int ADDR_W    = 64
) (
  input  logic [ADDR_W-1:0]           origin_i,
  input  logic [STRIDE_W-1:0]         sstride_i,
  output logic [NUM_LANES*ADDR_W-1:0] lanes_o
);
  logic [ADDR_W-1:0] lane_addr [NUM_LANES];

  assign lane_addr[0] = origin_i;

  for (genvar j = 1; j < NUM_LANES; j++) begin : g_lane
    assign lane_addr[j] = lane_addr[j-1] + ADDR_W'(sstride_i);
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_pack
    assign lanes_o[j*ADDR_W +: ADDR_W] = lane_addr[j];
  end
endmodule

// File: rtl/stride_lane_agu.sv
module stride_lane_agu
  import sag_pkg::*;
#(
  parameter int NUM_LOOPS = 2,
  parameter int NUM_LANES = 4,
  parameter int BOUND_W   = 16,
  parameter int STRIDE_W  = 32,
  parameter int ADDR_W    = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [31:0]                   base_lo_i,
  input  logic [31:0]                   base_hi_i,
  input  logic [NUM_LOOPS*BOUND_W-1:0]  bounds_i,
  input  logic [NUM_LOOPS*STRIDE_W-1:0] tstrides_i,
  input  logic [STRIDE_W-1:0]           sstride_i,
  output logic [NUM_LANES*ADDR_W-1:0]   addr_o,
  output logic                          valid_o,
  input  logic                          ready_i,
  output logic                          done_o
);
  walk_state_e state_q;

  logic [ADDR_W-1:0]             base_q;
  logic [NUM_LOOPS*BOUND_W-1:0]  bounds_q;
  logic [NUM_LOOPS*STRIDE_W-1:0] tstrides_q;
  logic [STRIDE_W-1:0]           sstride_q;

  logic                 fire;
  logic                 zero_in;
  logic [NUM_LOOPS-1:0] at_last;
  logic [NUM_LOOPS-1:0] step;
  logic [ADDR_W-1:0]    level_off [NUM_LOOPS];
  logic [ADDR_W-1:0]    origin;

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign fire    = valid_o && ready_i;

  always_comb begin
    zero_in = 1'b0;
    for (int k = 0; k < NUM_LOOPS; k++) begin
      if (bounds_i[k*BOUND_W +: BOUND_W] == '0) zero_in = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      bounds_q   <= '0;
      tstrides_q <= '0;
      sstride_q  <= '0;
    end else if (start_i) begin
      base_q     <= ADDR_W'({base_hi_i, base_lo_i});
      bounds_q   <= bounds_i;
      tstrides_q <= tstrides_i;
      sstride_q  <= sstride_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else if (start_i) begin
      state_q <= zero_in ? ST_DONE : ST_RUN;
    end else if (fire && (&at_last)) begin
      state_q <= ST_DONE;
    end
  end

  // Carry chain: loop 0 steps on every accepted beat, outer loops on carry.
  for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_level
    if (k == 0) begin : g_inner
      assign step[k] = fire;
    end else begin : g_outer
      assign step[k] = step[k-1] && at_last[k-1];
    end

    sag_loop_level #(
      .BOUND_W (BOUND_W),
      .STRIDE_W(STRIDE_W),
      .ADDR_W  (ADDR_W)
    ) u_level (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (start_i),
      .step_i   (step[k]),
      .bound_i  (bounds_q[k*BOUND_W +: BOUND_W]),
      .stride_i (tstrides_q[k*STRIDE_W +: STRIDE_W]),
      .at_last_o(at_last[k]),
      .offset_o (level_off[k])
    );
  end

  always_comb begin
    origin = base_q;
    for (int k = 0; k < NUM_LOOPS; k++) origin = origin + level_off[k];
  end

  sag_lane_fanout #(
    .NUM_LANES(NUM_LANES),
    .STRIDE_W (STRIDE_W),
    .ADDR_W   (ADDR_W)
  ) u_fanout (
    .origin_i (origin),
    .sstride_i(sstride_q),
    .lanes_o  (addr_o)
  );

  // R5: a stalled beat keeps valid and its addresses
  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !start_i |=> valid_o && $stable(addr_o));

  // R6: done and valid are exclusive
  a_r6_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  // R6: done persists until a start
  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  // R8: a zero bound at start ends the walk immediately
  a_r8_zero_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && zero_in |=> done_o && !valid_o);

  // R7 / R9: a start offers the assembled base on lane 0 next cycle
  a_r7_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !zero_in |=> valid_o &&
      (addr_o[ADDR_W-1:0] == ADDR_W'({$past(base_hi_i), $past(base_lo_i)})));

  // R3: neighbouring lanes are one spatial stride apart
  if (NUM_LANES > 1) begin : g_spacing
    a_r3_lane_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (addr_o[2*ADDR_W-1:ADDR_W] - addr_o[ADDR_W-1:0]) == ADDR_W'(sstride_q));
  end
endmodule

// File: tb/stride_lane_agu_tb.sv
`timescale 1ns/1ps
module stride_lane_agu_tb;
  localparam int NL = 2;
  localparam int NW = 3;
  localparam int BW = 16;
  localparam int SW = 32;
  localparam int AW = 64;

  typedef struct packed {
    logic [63:0] base;
    logic [15:0] b0;
    logic [15:0] b1;
    logic [31:0] s0;
    logic [31:0] s1;
    logic [31:0] ss;
    logic        stall;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0,                   16'd4, 16'd1, 32'd12, 32'd0,   32'd1,  1'b0},
    '{64'h0,                   16'd2, 16'd2, 32'd3,  32'd12,  32'd1,  1'b1},
    '{64'h1_0000_0100,         16'd3, 16'd2, 32'd8,  32'd100, 32'd2,  1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFE, 16'd2, 16'd1, 32'd1,  32'd0,   32'd1,  1'b0},
    '{64'h40,                  16'd1, 16'd1, 32'd5,  32'd7,   32'd16, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       base_lo = '0, base_hi = '0;
  logic [NL*BW-1:0]  bounds = '0;
  logic [NL*SW-1:0]  tstrides = '0;
  logic [SW-1:0]     sstride = '0;
  logic [NW*AW-1:0]  addr;
  logic              valid, ready = 1'b0, done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stride_lane_agu #(.NUM_LOOPS(NL), .NUM_LANES(NW), .BOUND_W(BW),
                    .STRIDE_W(SW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .base_lo_i(base_lo), .base_hi_i(base_hi),
    .bounds_i(bounds), .tstrides_i(tstrides), .sstride_i(sstride),
    .addr_o(addr), .valid_o(valid), .ready_i(ready), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_start(input vec_t v);
    @(negedge clk);
    base_lo  = v.base[31:0];
    base_hi  = v.base[63:32];
    bounds   = {v.b1, v.b0};
    tstrides = {v.s1, v.s0};
    sstride  = v.ss;
    start    = 1'b1;
    ready    = 1'b0;
    @(negedge clk);
    start    = 1'b0;
    // R10: scramble configuration pins after start; must be ignored
    base_lo  = 32'hDEAD_BEEF;
    base_hi  = 32'h1234_5678;
    bounds   = {16'd7, 16'd9};
    tstrides = {32'd999, 32'd555};
    sstride  = 32'd77;
  endtask

  function automatic logic [63:0] model(input vec_t v, input int o, input int i,
                                        input int l);
    return v.base + 64'(o) * 64'(v.s1) + 64'(i) * 64'(v.s0) + 64'(l) * 64'(v.ss);
  endfunction

  // Checks the offered beat at this negedge, then lets it be consumed.
  task automatic take_beat(input vec_t v, input int o, input int i, input bit stall);
    logic [NW*AW-1:0] held;
    if (stall) begin
      ready = 1'b0;
      #1;
      held = addr;
      @(negedge clk);
      check(valid === 1'b1, "R5 valid held under stall", 64'(valid), 64'd1);
      check(addr === held, "R5 addresses stable under stall", addr[63:0], held[63:0]);
    end
    ready = 1'b1;
    #1;
    check(valid === 1'b1, "R4 beat offered", 64'(valid), 64'd1);
    for (int l = 0; l < NW; l++) begin
      logic [63:0] e;
      e = model(v, o, i, l);
      // R2 R3 R9 R10: every lane of the step in one beat
      check(addr[l*AW +: AW] === e, "R2 lane address", addr[l*AW +: AW], e);
    end
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    apply_start(v);
    for (int o = 0; o < int'(v.b1); o++) begin
      for (int i = 0; i < int'(v.b0); i++) begin
        take_beat(v, o, i, v.stall && ((o + i) % 2 == 0));
      end
    end
    #1;
    check(done === 1'b1, "R6 done after final beat", 64'(done), 64'd1);
    check(valid === 1'b0, "R6 valid low after final beat", 64'(valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    vec_t zv, rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid === 1'b0, "R1 valid low in reset", 64'(valid), 64'd0);
    check(done === 1'b0, "R1 done low in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    ready = 1'b1;
    repeat (2) @(negedge clk);
    check(valid === 1'b0, "R1 valid low before start", 64'(valid), 64'd0);
    check(done === 1'b0, "R1 done low before start", 64'(done), 64'd0);

    // Table of stimulus vectors (R2 R3 R4 R5 R6 R9 R10)
    for (int n = 0; n < NVEC; n++) run_vec(VECS[n]);

    // R6: done persists with ready high and no start
    ready = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R6 done sticky", 64'(done), 64'd1);
    check(valid === 1'b0, "R6 no beats after done", 64'(valid), 64'd0);

    // R8: zero bound in the outer loop gives immediate done
    zv = '{64'h100, 16'd3, 16'd0, 32'd4, 32'd4, 32'd1, 1'b0};
    apply_start(zv);
    #1;
    check(done === 1'b1, "R8 done on zero bound", 64'(done), 64'd1);
    check(valid === 1'b0, "R8 no beat on zero bound", 64'(valid), 64'd0);

    // R7: restart in the middle of a run
    run_vec(VECS[1]);
    apply_start(VECS[2]);
    take_beat(VECS[2], 0, 0, 1'b0);
    take_beat(VECS[2], 0, 1, 1'b0);
    rv = '{64'h2000, 16'd2, 16'd1, 32'd16, 32'd0, 32'd4, 1'b0};
    apply_start(rv);
    #1;
    check(done === 1'b0, "R7 restart clears done", 64'(done), 64'd0);
    check(addr[63:0] === 64'h2000, "R7 restart begins at base", addr[63:0], 64'h2000);
    take_beat(rv, 0, 0, 1'b0);
    take_beat(rv, 0, 1, 1'b0);
    #1;
    check(done === 1'b1, "R7 restarted walk completes", 64'(done), 64'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule